// File: doc/BRIEF.md
# Event Builder Destination Selector

For every accepted trigger this block chooses which event-builder server and which UDP port get the event data. The choice spreads load over several destinations by reading low bits of the trigger number. A small destination table holds one MAC address and one IPv4 address per server slot. A single 16-bit base port is shared by all slots. The selected slot index, MAC, IP and port leave the block as one record.

Load sharing has a master enable and two width fields. The server width gives how many of the lowest trigger bits pick the table slot. The port width gives how many of the trigger bits directly above those pick an offset, and the offset is added to the base port. With sharing off, every trigger goes to slot 0 at the base port.

Triggers enter on a valid/ready stream and destinations leave on a valid/ready stream, with one register stage between them. A trigger is accepted on a clock edge where `trig_valid` and `trig_ready` are both high. `trig_ready` is high whenever the output register is empty or is being drained in that cycle. While `dst_valid` is high and `dst_ready` is low, the output record holds and the block takes no new trigger. The configuration pins and the table write port are plain level inputs. They are sampled on the clock edge that accepts a trigger.

Top module: `evb_dest_select`

## Requirements
- R1: After reset, `dst_valid` is low and all eight table slots read back as MAC 0 and IP 0.
- R2: While `share_en` is low, an accepted trigger yields slot 0 and port `base_port`, whatever the trigger number and width fields hold.
- R3: While `share_en` is high, the slot index equals the trigger number modulo 2^`srv_sel_bits` (a field value of 0, 1, 2 or 3 gives 1, 2, 4 or 8 slots).
- R4: The port offset is trigger bits [s+p-1:s], where s is the server width and p is the port width (0 to 4, giving 1 to 16 ports). The offset is 0 when p is 0.
- R5: A `port_sel_bits` value of 5, 6 or 7 behaves exactly like 4.
- R6: `dst_port` equals `base_port` plus the offset, modulo 2^16.
- R7: A cycle with `tbl_we` high stores `tbl_mac` and `tbl_ip` into slot `tbl_idx`. Later lookups of that slot return the stored values.
- R8: A trigger accepted at edge k appears on the output with `dst_valid` high after edge k. The output stays valid for exactly one cycle if `dst_ready` is high and no trigger is accepted at edge k+1. Triggers presented on consecutive cycles with `dst_ready` high give outputs on consecutive cycles.
- R9: While `dst_valid` is high and `dst_ready` is low, `trig_ready` is low and every `dst_*` output holds its value.
- R10: A trigger presented while `trig_ready` is low is dropped. It never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_en | input | 1 | Load sharing enable |
| srv_sel_bits | input | 2 | Number of trigger LSBs used to select the server slot |
| port_sel_bits | input | 3 | Number of next trigger bits used for the port offset (clamped to 4) |
| base_port | input | 16 | Base UDP port |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W (3) | Table slot to write |
| tbl_mac | input | 48 | MAC address to store |
| tbl_ip | input | 32 | IP address to store |
| trig_valid | input | 1 | Trigger number valid |
| trig_ready | output | 1 | Block can accept a trigger |
| trig_num | input | TRIG_W (24) | Trigger number |
| dst_valid | output | 1 | Destination record valid |
| dst_ready | input | 1 | Consumer takes the destination record |
| dst_idx | output | IDX_W (3) | Selected server slot |
| dst_mac | output | 48 | Selected MAC address |
| dst_ip | output | 32 | Selected IP address |
| dst_port | output | 16 | Selected UDP port |

## Verification
Each destination record is due exactly one clock edge after the edge that accepts its trigger. `trig_ready` follows in the same cycle as the consumer's `dst_ready`. The bench keeps a behavioural model that steps on every rising edge. It compares valid, ready and the whole record at the following falling edge, so the check always falls in the cycle the result is due. Stimulus changes one time unit after the rising edge. Table writes, stalls and dropped triggers therefore land on known edges in both the model and the design.

// File: rtl/evb_dsel_pkg.sv
`timescale 1ns/1ps
package evb_dsel_pkg;
  localparam int MAC_W         = 48;
  localparam int IP_W          = 32;
  localparam int PORT_W        = 16;
  localparam int SRV_SEL_W     = 2;
  localparam int PRT_SEL_W     = 3;
  localparam int MAX_PORT_BITS = 4;

  typedef struct packed {
    logic [MAC_W-1:0] mac;
    logic [IP_W-1:0]  ip;
  } dest_entry_t;
endpackage

// File: rtl/evb_dsel_field.sv
`timescale 1ns/1ps
// Splits the trigger number into a server slot and a port offset.
module evb_dsel_field
  import evb_dsel_pkg::*;
#(
  parameter int TRIG_W = 24,
  parameter int IDX_W  = 3
) (
  input  logic                     share_en,
  input  logic [SRV_SEL_W-1:0]     srv_bits,
  input  logic [PRT_SEL_W-1:0]     prt_bits,
  input  logic [TRIG_W-1:0]        trig,
  output logic [IDX_W-1:0]         srv_idx,
  output logic [MAX_PORT_BITS-1:0] port_off
);
  localparam int CNT_W = 4;

  logic [CNT_W-1:0]  srv_n;
  logic [CNT_W-1:0]  prt_n;
  logic [TRIG_W-1:0] upper;

  // Effective field widths: zero when sharing is off; port width clamped.
  always_comb begin
    srv_n = '0;
    prt_n = '0;
    if (share_en) begin
      srv_n = CNT_W'(srv_bits);
      if (srv_n > CNT_W'(IDX_W)) srv_n = CNT_W'(IDX_W);
      if (prt_bits > PRT_SEL_W'(MAX_PORT_BITS)) prt_n = CNT_W'(MAX_PORT_BITS);
      else                                      prt_n = CNT_W'(prt_bits);
    end
  end

  // Port bits sit directly above the server bits.
  assign upper = trig >> srv_n;

  for (genvar k = 0; k < IDX_W; k++) begin : g_srv
    assign srv_idx[k] = trig[k] & (CNT_W'(k) < srv_n);
  end

  for (genvar k = 0; k < MAX_PORT_BITS; k++) begin : g_prt
    assign port_off[k] = upper[k] & (CNT_W'(k) < prt_n);
  end
endmodule

// File: rtl/evb_dsel_table.sv
`timescale 1ns/1ps
// Destination table: one write port, one combinational read port.
module evb_dsel_table
  import evb_dsel_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic [IP_W-1:0]  wr_ip,
  input  logic [IDX_W-1:0] rd_idx,
  output dest_entry_t      rd_entry
);
  dest_entry_t slots [N_ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) slots[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < N_ENTRIES)) begin
      slots[wr_idx] <= '{mac: wr_mac, ip: wr_ip};
    end
  end

  assign rd_entry = (int'(rd_idx) < N_ENTRIES) ? slots[rd_idx] : '0;

  // R7: a write is visible in the addressed slot on the next cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slots[$past(wr_idx)].mac == $past(wr_mac)) &&
              (slots[$past(wr_idx)].ip  == $past(wr_ip)));
endmodule

// File: rtl/evb_dsel_outreg.sv
`timescale 1ns/1ps
// Single valid/ready register stage.
module evb_dsel_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8: an accepted input is presented on the next cycle
  a_r8_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && (out_data == $past(in_data))));

  // R9: a stalled record holds
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/evb_dest_select.sv
`timescale 1ns/1ps
module evb_dest_select
  import evb_dsel_pkg::*;
#(
  parameter int  TRIG_W    = 24,
  parameter int  N_ENTRIES = 8,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 share_en,
  input  logic [SRV_SEL_W-1:0] srv_sel_bits,
  input  logic [PRT_SEL_W-1:0] port_sel_bits,
  input  logic [PORT_W-1:0]    base_port,
  input  logic                 tbl_we,
  input  logic [IDX_W-1:0]     tbl_idx,
  input  logic [MAC_W-1:0]     tbl_mac,
  input  logic [IP_W-1:0]      tbl_ip,
  input  logic                 trig_valid,
  output logic                 trig_ready,
  input  logic [TRIG_W-1:0]    trig_num,
  output logic                 dst_valid,
  input  logic                 dst_ready,
  output logic [IDX_W-1:0]     dst_idx,
  output logic [MAC_W-1:0]     dst_mac,
  output logic [IP_W-1:0]      dst_ip,
  output logic [PORT_W-1:0]    dst_port
);
  localparam int DATA_W = IDX_W + MAC_W + IP_W + PORT_W;

  logic [IDX_W-1:0]         sel_idx;
  logic [MAX_PORT_BITS-1:0] sel_off;
  dest_entry_t              sel_entry;
  logic [PORT_W-1:0]        sel_port;
  logic [DATA_W-1:0]        rec_in;
  logic [DATA_W-1:0]        rec_out;

  evb_dsel_field #(.TRIG_W(TRIG_W), .IDX_W(IDX_W)) u_field (
    .share_en (share_en),
    .srv_bits (srv_sel_bits),
    .prt_bits (port_sel_bits),
    .trig     (trig_num),
    .srv_idx  (sel_idx),
    .port_off (sel_off)
  );

  evb_dsel_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_mac   (tbl_mac),
    .wr_ip    (tbl_ip),
    .rd_idx   (sel_idx),
    .rd_entry (sel_entry)
  );

  assign sel_port = base_port + PORT_W'(sel_off);
  assign rec_in   = {sel_idx, sel_entry.mac, sel_entry.ip, sel_port};

  evb_dsel_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (trig_valid),
    .in_ready  (trig_ready),
    .in_data   (rec_in),
    .out_valid (dst_valid),
    .out_ready (dst_ready),
    .out_data  (rec_out)
  );

  assign {dst_idx, dst_mac, dst_ip, dst_port} = rec_out;

  // R2: with sharing off the record points at slot 0 and the base port
  a_r2_share_off: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready && !share_en) |=>
      (dst_idx == '0) && (dst_port == $past(base_port)));

  // R5: the port offset never exceeds 4 bits, whatever the field value
  a_r5_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=>
      (PORT_W'(dst_port - $past(base_port)) < PORT_W'(16)));

  // R4: a port width of zero adds no offset
  a_r4_no_port_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready && (port_sel_bits == '0)) |=>
      (dst_port == $past(base_port)));

  // R9: no trigger is taken while the output is stalled
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |-> !trig_ready);
endmodule

// File: tb/sim_evb_dest_select.sv
`timescale 1ns/1ps
module sim_evb_dest_select;
  localparam int CLK_PERIOD = 10;
  localparam int TRIG_W = 24;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic share_en;
  logic [1:0] srv_sel_bits;
  logic [2:0] port_sel_bits;
  logic [15:0] base_port;
  logic tbl_we;
  logic [IW-1:0] tbl_idx;
  logic [47:0] tbl_mac;
  logic [31:0] tbl_ip;
  logic trig_valid, trig_ready;
  logic [TRIG_W-1:0] trig_num;
  logic dst_valid, dst_ready;
  logic [IW-1:0] dst_idx;
  logic [47:0] dst_mac;
  logic [31:0] dst_ip;
  logic [15:0] dst_port;

  evb_dest_select #(.TRIG_W(TRIG_W), .N_ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .share_en(share_en), .srv_sel_bits(srv_sel_bits),
    .port_sel_bits(port_sel_bits), .base_port(base_port), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_mac(tbl_mac), .tbl_ip(tbl_ip),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_num(trig_num),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_idx(dst_idx),
    .dst_mac(dst_mac), .dst_ip(dst_ip), .dst_port(dst_port)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state
  logic [47:0] m_mac [N];
  logic [31:0] m_ip  [N];
  bit          e_valid;
  int          e_idx;
  logic [47:0] e_mac;
  logic [31:0] e_ip;
  logic [15:0] e_port;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", r, act, exp, $time);
    end
  endtask

  function automatic void ref_pick(input logic [TRIG_W-1:0] t, input logic en,
                                   input logic [1:0] sb, input logic [2:0] pb,
                                   input logic [15:0] base,
                                   output int idx, output logic [15:0] port);
    int sn, pn, off;
    sn   = en ? int'(sb) : 0;
    pn   = en ? ((pb > 3'd4) ? 4 : int'(pb)) : 0;
    idx  = int'(t) % (1 << sn);
    off  = (int'(t) >> sn) % (1 << pn);
    port = 16'((int'(base) + off) % 65536);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      for (int i = 0; i < N; i++) begin
        m_mac[i] <= '0;
        m_ip[i]  <= '0;
      end
    end else begin
      if (trig_valid && (!e_valid || dst_ready)) begin
        int          ix;
        logic [15:0] pt;
        ref_pick(trig_num, share_en, srv_sel_bits, port_sel_bits, base_port, ix, pt);
        e_valid <= 1'b1;
        e_idx   <= ix;
        e_mac   <= m_mac[ix];
        e_ip    <= m_ip[ix];
        e_port  <= pt;
      end else if (dst_ready) begin
        e_valid <= 1'b0;
      end
      if (tbl_we) begin
        m_mac[tbl_idx] <= tbl_mac;
        m_ip[tbl_idx]  <= tbl_ip;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R8 valid", 64'(dst_valid), 64'(e_valid));
      chk("R9 ready", 64'(trig_ready), 64'(!e_valid || dst_ready));
      if (e_valid) begin
        chk({cur_req, " idx"},  64'(dst_idx),  64'(e_idx));
        chk({cur_req, " mac"},  64'(dst_mac),  64'(e_mac));
        chk({cur_req, " ip"},   64'(dst_ip),   64'(e_ip));
        chk({cur_req, " port"}, 64'(dst_port), 64'(e_port));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic [TRIG_W-1:0] t);
    trig_valid = 1'b1;
    trig_num   = t;
    tick();
    trig_valid = 1'b0;
  endtask

  task automatic wr(input int i, input logic [47:0] mac, input logic [31:0] ip);
    tbl_we  = 1'b1;
    tbl_idx = IW'(i);
    tbl_mac = mac;
    tbl_ip  = ip;
    tick();
    tbl_we  = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; share_en = 0; srv_sel_bits = 0; port_sel_bits = 0; base_port = 0;
    tbl_we = 0; tbl_idx = 0; tbl_mac = 0; tbl_ip = 0;
    trig_valid = 0; trig_num = 0; dst_ready = 1;
    repeat (3) tick();
    chk("R1 reset valid", 64'(dst_valid), 64'd0);
    rst_n = 1;
    tick();

    // R1: empty table reads as zero
    cur_req = "R1";
    share_en = 1; srv_sel_bits = 3;
    for (int t = 0; t < 8; t++) strobe(TRIG_W'(t));
    tick();

    // R7: fill table, then look each slot up
    cur_req = "R7";
    for (int i = 0; i < N; i++)
      wr(i, 48'h02AB_0000_0000 + 48'(i) * 48'h0001_0101_0101, 32'h0A00_0000 + 32'(i) * 32'd17);
    for (int t = 0; t < 8; t++) strobe(TRIG_W'(7 - t));
    tick();

    // R2: sharing off
    cur_req = "R2";
    share_en = 0; srv_sel_bits = 3; port_sel_bits = 4; base_port = 16'd1000;
    for (int t = 0; t < 8; t++) strobe(TRIG_W'(t * 37 + 5));
    tick();

    // R3: server width sweep
    cur_req = "R3";
    share_en = 1; port_sel_bits = 1; base_port = 16'd2000;
    for (int s = 0; s < 4; s++) begin
      srv_sel_bits = 2'(s);
      for (int t = 0; t < 10; t++) strobe(TRIG_W'(t * 13 + 1));
    end
    tick();

    // R4: port width sweep above the server bits
    cur_req = "R4";
    srv_sel_bits = 1; base_port = 16'h4000;
    for (int p = 0; p < 5; p++) begin
      port_sel_bits = 3'(p);
      for (int t = 0; t < 20; t++) strobe(TRIG_W'(t * 7 + 3));
    end
    tick();

    // R5: out-of-range port widths clamp to 4
    cur_req = "R5";
    srv_sel_bits = 2;
    for (int p = 5; p < 8; p++) begin
      port_sel_bits = 3'(p);
      for (int t = 0; t < 16; t++) strobe(TRIG_W'(t * 29 + 2));
    end
    tick();

    // R6: base port wrap
    cur_req = "R6";
    srv_sel_bits = 0; port_sel_bits = 4; base_port = 16'hFFFA;
    for (int t = 0; t < 16; t++) strobe(TRIG_W'(t));
    tick();

    // R8: back-to-back triggers
    cur_req = "R8";
    srv_sel_bits = 3; port_sel_bits = 2; base_port = 16'd5000;
    trig_valid = 1;
    for (int t = 0; t < 12; t++) begin
      trig_num = TRIG_W'(t * 11 + 4);
      tick();
    end
    trig_valid = 0;
    tick();

    // R9 / R10: stall, present ignored triggers, then release
    cur_req = "R9";
    dst_ready = 0;
    strobe(TRIG_W'(21));
    tick();
    cur_req = "R10";
    strobe(TRIG_W'(42));
    strobe(TRIG_W'(63));
    tick();
    dst_ready = 1;
    tick();
    strobe(TRIG_W'(6));
    dst_ready = 0;
    trig_valid = 1; trig_num = TRIG_W'(15);
    repeat (3) tick();
    dst_ready = 1;
    repeat (2) tick();
    trig_valid = 0;
    repeat (3) tick();

    done = 1;
    summary();
    $finish;
  end
endmodule